// File: doc/BRIEF.md
# Segment Protection Checker

This block keeps cached copies of six segment descriptors and checks every memory access made through them. For each segment it keeps a 32-bit base, a limit scaled to bytes, and the attribute fields taken from the descriptor: present, privilege level, memory/system flag, type and default operand size. An access names a segment, a 32-bit offset, an access kind, an access size and the current privilege level. The block answers in the same cycle with either the linear address or a fault and its cause.

A loader fills the cache. It presents a 16-bit selector and the raw 8-byte descriptor on the load port. The block decodes the descriptor once, when it is written, so the access path only compares fields that are already decoded. Walking descriptor tables in memory, paging, gates and task switching all stay outside the block.

Top module: `seg_guard`

## Requirements
- R1: While reset is asserted and after it is released, every cache entry is marked not present. An access through any segment then faults with cause 1.
- R2: A load strobed on `ld_valid` is written at the next rising clock edge. An access in the same cycle still sees the previous entry. `acc_sel` returns the selector stored for the segment being accessed, or 0 for an index of 6 or more.
- R3: The descriptor layout is fixed as follows. The limit is bits 15:0 with bits 51:48 above them. The base is bits 39:16 with bits 63:56 above them. The attribute byte is bits 47:40, holding present in bit 7, privilege level in bits 6:5, memory flag in bit 4 and type in bits 3:0. Granularity is bit 55 and default size is bit 54.
- R4: With granularity 0 the effective limit is the 20-bit limit in bytes. With granularity 1 it is limit*4096+4095.
- R5: An access covers 2^size bytes (size code 0 to 3). It faults with cause 2 when offset+2^size-1 is greater than the effective limit. This sum is evaluated without 32-bit wraparound.
- R6: With the default-size bit at 0, only the low 16 bits of the offset are used, both for the limit check and for the address.
- R7: An access without a fault returns linear address = base + effective offset, modulo 2^32.
- R8: An access through an entry whose present bit is 0 faults with cause 1.
- R9: Type check, where type bit 3 means executable and type bit 1 means readable (code) or writable (data). A fetch (kind 0) needs an executable type. A read (kind 1) needs a data type or a readable code type. A write (kind 2) needs a writable data type. Kind 3, and any access to an entry with memory flag 0, fault with cause 3.
- R10: An access whose privilege level is numerically greater than the segment's level faults with cause 4.
- R11: The cause encoding is 0 none, 1 not present, 2 limit, 3 type, 4 privilege. When several checks fail, the cause reported is the first of: not present, type, privilege, limit. `acc_fault` is high exactly when the cause is not 0.
- R12: A segment index of 6 or 7 faults with cause 1.
- R13: While `acc_valid` is low, `acc_fault` is 0 and `acc_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe |
| ld_seg | input | 3 | Segment register to write |
| ld_sel | input | 16 | Selector stored with the entry |
| ld_desc | input | 64 | Raw 8-byte descriptor |
| acc_valid | input | 1 | Access request |
| acc_seg | input | 3 | Segment register used by the access |
| acc_off | input | 32 | Offset within the segment |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write |
| acc_size | input | 2 | Access size code, 2^size bytes |
| acc_cpl | input | 2 | Current privilege level |
| acc_lin | output | 32 | Linear address |
| acc_fault | output | 1 | Access faults |
| acc_cause | output | 3 | Fault cause code |
| acc_sel | output | 16 | Selector of the accessed segment |

## Verification
The hardest cases to reach are those where several checks fail on one access. Examples are a write from an outer ring to a read-only segment at its limit edge, and an access whose last byte passes the 4 GB mark under page granularity. Here the priority order and the unwrapped sum have to decide the answer. The bench reaches them by loading descriptors that combine level, type, granularity and size. For each descriptor it sweeps every kind, privilege level and access size over offsets clustered around the effective limit and the 64 KB fold. A load and an access in the same cycle are driven on purpose, so the one-cycle visibility rule is observed at the ports.

// File: rtl/seg_guard_pkg.sv
`timescale 1ns/1ps
package seg_guard_pkg;
  localparam int OFF_W   = 32;
  localparam int SEL_W   = 16;
  localparam int DESC_W  = 64;
  localparam int LIM_W   = 20;
  localparam int GRAN_SH = 12;
  localparam int SHORT_W = 16;
  localparam int SIZE_W  = 2;
  localparam int PL_W    = 2;
  localparam int TYP_W   = 4;
  localparam int KIND_W  = 2;
  localparam int CAUSE_W = 3;
  localparam int SPAN_W  = OFF_W + 1;

  localparam logic [KIND_W-1:0] KIND_FETCH = 2'd0;
  localparam logic [KIND_W-1:0] KIND_READ  = 2'd1;
  localparam logic [KIND_W-1:0] KIND_WRITE = 2'd2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_ABSENT = 3'd1,
    CAUSE_LIMIT  = 3'd2,
    CAUSE_TYPE   = 3'd3,
    CAUSE_PRIV   = 3'd4
  } cause_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] base;
    logic [OFF_W-1:0] lim_eff;
    logic             present;
    logic [PL_W-1:0]  dpl;
    logic             mem;
    logic [TYP_W-1:0] typ;
    logic             big;
  } seg_entry_t;

  // R4: byte limit or page-scaled limit
  function automatic logic [OFF_W-1:0] scale_limit(input logic [LIM_W-1:0] raw,
                                                   input logic gran);
    if (gran) scale_limit = OFF_W'({raw, {GRAN_SH{1'b1}}});
    else      scale_limit = OFF_W'(raw);
  endfunction

  // R6: 16-bit segments see only the low offset half
  function automatic logic [OFF_W-1:0] fold_offset(input logic [OFF_W-1:0] off,
                                                   input logic big);
    if (big) fold_offset = off;
    else     fold_offset = OFF_W'(off[SHORT_W-1:0]);
  endfunction

  // R5: address of the last byte touched, one bit wider than the offset
  function automatic logic [SPAN_W-1:0] span_end(input logic [OFF_W-1:0] off,
                                                 input logic [SIZE_W-1:0] size);
    span_end = SPAN_W'(off) + SPAN_W'((1 << size) - 1);
  endfunction

  // R9: exec bit is type[3]; type[1] is readable for code, writable for data
  function automatic logic type_permits(input logic [TYP_W-1:0] typ,
                                        input logic mem,
                                        input logic [KIND_W-1:0] kind);
    logic exe;
    logic rw;
    exe = typ[3];
    rw  = typ[1];
    type_permits = 1'b0;
    if (mem) begin
      case (kind)
        KIND_FETCH: type_permits = exe;
        KIND_READ:  type_permits = !exe || rw;
        KIND_WRITE: type_permits = !exe && rw;
        default:    type_permits = 1'b0;
      endcase
    end
  endfunction

  // R11: priority absent > type > privilege > limit
  function automatic cause_t pick_cause(input logic absent, input logic type_bad,
                                        input logic priv_bad, input logic lim_bad);
    if (absent)        pick_cause = CAUSE_ABSENT;
    else if (type_bad) pick_cause = CAUSE_TYPE;
    else if (priv_bad) pick_cause = CAUSE_PRIV;
    else if (lim_bad)  pick_cause = CAUSE_LIMIT;
    else               pick_cause = CAUSE_NONE;
  endfunction
endpackage

// File: rtl/seg_desc_decode.sv
`timescale 1ns/1ps
module seg_desc_decode
  import seg_guard_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [SEL_W-1:0]  sel,
  output seg_entry_t        ent
);
  // R3: field positions inside the 8-byte descriptor
  localparam int LIM_LO_W   = 16;
  localparam int BASE_LO_AT = 16;
  localparam int BASE_LO_W  = 24;
  localparam int ATTR_AT    = 40;
  localparam int ATTR_W     = 8;
  localparam int LIM_HI_AT  = 48;
  localparam int LIM_HI_W   = LIM_W - LIM_LO_W;
  localparam int BIG_BIT    = 54;
  localparam int GRAN_BIT   = 55;
  localparam int BASE_HI_AT = 56;
  localparam int BASE_HI_W  = OFF_W - BASE_LO_W;

  logic [ATTR_W-1:0] attr;
  logic [LIM_W-1:0]  raw_lim;
  logic [OFF_W-1:0]  raw_base;
  logic [1:0]        unused_flags;

  assign attr     = desc[ATTR_AT +: ATTR_W];
  assign raw_lim  = {desc[LIM_HI_AT +: LIM_HI_W], desc[0 +: LIM_LO_W]};
  assign raw_base = {desc[BASE_HI_AT +: BASE_HI_W], desc[BASE_LO_AT +: BASE_LO_W]};
  assign unused_flags = desc[BIG_BIT-1 -: 2];

  always_comb begin
    ent.sel     = sel;
    ent.base    = raw_base;
    ent.lim_eff = scale_limit(raw_lim, desc[GRAN_BIT]);
    ent.present = attr[7];
    ent.dpl     = attr[6:5];
    ent.mem     = attr[4];
    ent.typ     = attr[TYP_W-1:0];
    ent.big     = desc[BIG_BIT];
  end
endmodule

// File: rtl/seg_cache_bank.sv
`timescale 1ns/1ps
module seg_cache_bank
  import seg_guard_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  seg_entry_t       wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  output seg_entry_t       rd_ent,
  output logic             rd_hit
);
  seg_entry_t        bank [NUM_SEG];
  logic [NUM_SEG-1:0] slot_we;

  genvar g;
  generate
    for (g = 0; g < NUM_SEG; g++) begin : g_we
      assign slot_we[g] = wr_en && (wr_idx == IDX_W'(g));
    end
  endgenerate

  // R1 reset clears presence; R2 write lands on the next edge
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SEG; i++) begin
      if (!rst_n)          bank[i] <= '0;
      else if (slot_we[i]) bank[i] <= wr_ent;
    end
  end

  // R12: indices past the bank read as a miss
  always_comb begin
    rd_ent = '0;
    rd_hit = 1'b0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_ent = bank[i];
        rd_hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seg_access_check.sv
`timescale 1ns/1ps
module seg_access_check
  import seg_guard_pkg::*;
(
  input  logic              valid,
  input  logic              hit,
  input  logic              present,
  input  logic [PL_W-1:0]   dpl,
  input  logic              mem,
  input  logic [TYP_W-1:0]  typ,
  input  logic              big,
  input  logic [OFF_W-1:0]  base,
  input  logic [OFF_W-1:0]  lim_eff,
  input  logic [OFF_W-1:0]  off,
  input  logic [KIND_W-1:0] kind,
  input  logic [SIZE_W-1:0] size,
  input  logic [PL_W-1:0]   cpl,
  output logic [OFF_W-1:0]  lin,
  output logic              fault,
  output logic [CAUSE_W-1:0] cause,
  output logic [OFF_W-1:0]  off_eff,
  output logic [SPAN_W-1:0] span_last
);
  logic   absent;
  logic   type_bad;
  logic   priv_bad;
  logic   lim_bad;
  cause_t why;
  logic   unused_typ;

  assign unused_typ = ^{typ[2], typ[0]};

  // R6 / R5
  assign off_eff   = fold_offset(off, big);
  assign span_last = span_end(off_eff, size);

  // R8 / R12
  assign absent   = !hit || !present;
  // R9
  assign type_bad = !type_permits(typ, mem, kind);
  // R10
  assign priv_bad = cpl > dpl;
  // R5
  assign lim_bad  = span_last > SPAN_W'(lim_eff);

  // R11 / R13
  assign why   = valid ? pick_cause(absent, type_bad, priv_bad, lim_bad) : CAUSE_NONE;
  assign cause = why;
  assign fault = valid && (absent || type_bad || priv_bad || lim_bad);

  // R7
  assign lin = base + off_eff;
endmodule

// File: rtl/seg_guard.sv
`timescale 1ns/1ps
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  input  logic [IDX_W-1:0]   ld_seg,
  input  logic [SEL_W-1:0]   ld_sel,
  input  logic [DESC_W-1:0]  ld_desc,
  input  logic               acc_valid,
  input  logic [IDX_W-1:0]   acc_seg,
  input  logic [OFF_W-1:0]   acc_off,
  input  logic [KIND_W-1:0]  acc_kind,
  input  logic [SIZE_W-1:0]  acc_size,
  input  logic [PL_W-1:0]    acc_cpl,
  output logic [OFF_W-1:0]   acc_lin,
  output logic               acc_fault,
  output logic [CAUSE_W-1:0] acc_cause,
  output logic [SEL_W-1:0]   acc_sel
);
  // named internal events, observed by the bound checker
  seg_entry_t        ld_ent;
  seg_entry_t        cur_ent;
  logic              cur_hit;
  logic              ld_present;
  logic              cur_present;
  logic [PL_W-1:0]   cur_dpl;
  logic              cur_exec;
  logic [OFF_W-1:0]  cur_base;
  logic [OFF_W-1:0]  cur_lim;
  logic [OFF_W-1:0]  off_eff;
  logic [SPAN_W-1:0] span_last;

  seg_desc_decode u_dec (
    .desc (ld_desc),
    .sel  (ld_sel),
    .ent  (ld_ent)
  );

  seg_cache_bank #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ld_valid),
    .wr_idx (ld_seg),
    .wr_ent (ld_ent),
    .rd_idx (acc_seg),
    .rd_ent (cur_ent),
    .rd_hit (cur_hit)
  );

  seg_access_check u_chk (
    .valid     (acc_valid),
    .hit       (cur_hit),
    .present   (cur_ent.present),
    .dpl       (cur_ent.dpl),
    .mem       (cur_ent.mem),
    .typ       (cur_ent.typ),
    .big       (cur_ent.big),
    .base      (cur_ent.base),
    .lim_eff   (cur_ent.lim_eff),
    .off       (acc_off),
    .kind      (acc_kind),
    .size      (acc_size),
    .cpl       (acc_cpl),
    .lin       (acc_lin),
    .fault     (acc_fault),
    .cause     (acc_cause),
    .off_eff   (off_eff),
    .span_last (span_last)
  );

  // R2: selector of the addressed entry
  assign acc_sel     = cur_ent.sel;
  assign ld_present  = ld_ent.present;
  assign cur_present = cur_hit && cur_ent.present;
  assign cur_dpl     = cur_ent.dpl;
  assign cur_exec    = cur_ent.typ[3];
  assign cur_base    = cur_ent.base;
  assign cur_lim     = cur_ent.lim_eff;
endmodule

// File: rtl/seg_guard_chk.sv
`timescale 1ns/1ps
module seg_guard_chk
  import seg_guard_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ld_valid,
  input logic [IDX_W-1:0]   ld_seg,
  input logic               ld_present,
  input logic               acc_valid,
  input logic [IDX_W-1:0]   acc_seg,
  input logic [KIND_W-1:0]  acc_kind,
  input logic [PL_W-1:0]    acc_cpl,
  input logic [OFF_W-1:0]   acc_lin,
  input logic               acc_fault,
  input logic [CAUSE_W-1:0] acc_cause,
  input logic               cur_present,
  input logic [PL_W-1:0]    cur_dpl,
  input logic               cur_exec,
  input logic [OFF_W-1:0]   cur_base,
  input logic [OFF_W-1:0]   cur_lim,
  input logic [OFF_W-1:0]   off_eff,
  input logic [SPAN_W-1:0]  span_last
);
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_fault && acc_cause == CAUSE_NONE));

  // R8
  absent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !cur_present) |-> acc_cause == CAUSE_ABSENT);

  // R2
  load_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ld_valid) && !$past(ld_present) && acc_valid && acc_seg == $past(ld_seg))
      |-> acc_cause == CAUSE_ABSENT);

  // R9
  write_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cur_present && acc_kind == KIND_WRITE && cur_exec)
      |-> acc_cause == CAUSE_TYPE);

  // R10
  ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cur_present && acc_cause != CAUSE_TYPE && acc_cpl > cur_dpl)
      |-> acc_cause == CAUSE_PRIV);

  // R5
  span_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_fault) |-> span_last <= SPAN_W'(cur_lim));

  // R7
  lin_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_fault) |-> acc_lin == cur_base + off_eff);

  // R11
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault == (acc_cause != CAUSE_NONE));
endmodule

bind seg_guard seg_guard_chk #(.IDX_W(IDX_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .ld_valid    (ld_valid),
  .ld_seg      (ld_seg),
  .ld_present  (ld_present),
  .acc_valid   (acc_valid),
  .acc_seg     (acc_seg),
  .acc_kind    (acc_kind),
  .acc_cpl     (acc_cpl),
  .acc_lin     (acc_lin),
  .acc_fault   (acc_fault),
  .acc_cause   (acc_cause),
  .cur_present (cur_present),
  .cur_dpl     (cur_dpl),
  .cur_exec    (cur_exec),
  .cur_base    (cur_base),
  .cur_lim     (cur_lim),
  .off_eff     (off_eff),
  .span_last   (span_last)
);

// File: tb/sim_seg_guard.sv
`timescale 1ns/1ps
module sim_seg_guard;
  localparam int NCFG = 9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid;
  logic [2:0]  ld_seg;
  logic [15:0] ld_sel;
  logic [63:0] ld_desc;
  logic        acc_valid;
  logic [2:0]  acc_seg;
  logic [31:0] acc_off;
  logic [1:0]  acc_kind;
  logic [1:0]  acc_size;
  logic [1:0]  acc_cpl;
  logic [31:0] acc_lin;
  logic        acc_fault;
  logic [2:0]  acc_cause;
  logic [15:0] acc_sel;

  always #5 clk = ~clk;

  seg_guard u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_desc(ld_desc),
    .acc_valid(acc_valid), .acc_seg(acc_seg), .acc_off(acc_off),
    .acc_kind(acc_kind), .acc_size(acc_size), .acc_cpl(acc_cpl),
    .acc_lin(acc_lin), .acc_fault(acc_fault), .acc_cause(acc_cause), .acc_sel(acc_sel)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] c_base [NCFG];
  logic [19:0] c_lim  [NCFG];
  bit          c_gran [NCFG];
  bit          c_big  [NCFG];
  logic [7:0]  c_attr [NCFG];

  task automatic note(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R3: pack the configuration fields into descriptor bit positions
  function automatic logic [63:0] mk_desc(input int c);
    logic [63:0] d;
    d = 64'd0;
    d[15:0]  = c_lim[c][15:0];
    d[51:48] = c_lim[c][19:16];
    d[39:16] = c_base[c][23:0];
    d[63:56] = c_base[c][31:24];
    d[47:40] = c_attr[c];
    d[55]    = c_gran[c];
    d[54]    = c_big[c];
    return d;
  endfunction

  function automatic longint eff_limit(input int c);
    // R4
    if (c_gran[c]) return longint'(c_lim[c]) * 4096 + 4095;
    return longint'(c_lim[c]);
  endfunction

  function automatic void model(input int c, input int kind, input int size,
                                input int cpl, input logic [31:0] off,
                                output int cause, output logic [31:0] lin);
    longint eo;
    longint last;
    bit present, mem, code, rw, ok_type;
    int dpl;
    present = c_attr[c][7];
    dpl     = int'(c_attr[c][6:5]);
    mem     = c_attr[c][4];
    code    = c_attr[c][3];
    rw      = c_attr[c][1];
    eo      = c_big[c] ? longint'(off) : longint'(off) % 65536;   // R6
    last    = eo + (longint'(1) << size) - 1;                      // R5
    case (kind)
      0: ok_type = code;
      1: ok_type = (!code) || rw;
      2: ok_type = (!code) && rw;
      default: ok_type = 1'b0;
    endcase
    if (!mem) ok_type = 1'b0;
    if (!present)          cause = 1;
    else if (!ok_type)     cause = 3;
    else if (cpl > dpl)    cause = 4;
    else if (last > eff_limit(c)) cause = 2;
    else                   cause = 0;
    lin = 32'(longint'(c_base[c]) + eo);                           // R7
  endfunction

  task automatic load(input int seg, input logic [15:0] sel, input int c);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_seg   = 3'(seg);
    ld_sel   = sel;
    ld_desc  = mk_desc(c);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic probe(input int seg, input logic [31:0] off, input int kind,
                       input int size, input int cpl);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_seg   = 3'(seg);
    acc_off   = off;
    acc_kind  = 2'(kind);
    acc_size  = 2'(size);
    acc_cpl   = 2'(cpl);
    #2;
  endtask

  function automatic string tag_of(input int cause);
    case (cause)
      0: return "R7";
      1: return "R8";
      2: return "R5";
      3: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    c_base[0] = 32'h0010_0000; c_lim[0] = 20'h002FF; c_gran[0] = 0; c_big[0] = 1; c_attr[0] = 8'h92;
    c_base[1] = 32'h0010_0000; c_lim[1] = 20'h002FF; c_gran[1] = 0; c_big[1] = 1; c_attr[1] = 8'h9A;
    c_base[2] = 32'h000B_8000; c_lim[2] = 20'h00FFF; c_gran[2] = 0; c_big[2] = 0; c_attr[2] = 8'h98;
    c_base[3] = 32'hC000_0000; c_lim[3] = 20'h0000F; c_gran[3] = 1; c_big[3] = 1; c_attr[3] = 8'h90;
    c_base[4] = 32'h1234_5678; c_lim[4] = 20'hFFFFF; c_gran[4] = 1; c_big[4] = 1; c_attr[4] = 8'hF2;
    c_base[5] = 32'hFFFF_F000; c_lim[5] = 20'h12345; c_gran[5] = 0; c_big[5] = 0; c_attr[5] = 8'hB2;
    c_base[6] = 32'h0000_0000; c_lim[6] = 20'h00100; c_gran[6] = 0; c_big[6] = 1; c_attr[6] = 8'h12;
    c_base[7] = 32'h0000_0100; c_lim[7] = 20'h00100; c_gran[7] = 0; c_big[7] = 1; c_attr[7] = 8'h82;
    c_base[8] = 32'h0005_3030; c_lim[8] = 20'h00003; c_gran[8] = 1; c_big[8] = 1; c_attr[8] = 8'hD8;

    rst_n = 1'b0; ld_valid = 1'b0; ld_seg = '0; ld_sel = '0; ld_desc = '0;
    acc_valid = 1'b0; acc_seg = '0; acc_off = '0; acc_kind = '0; acc_size = '0; acc_cpl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every entry absent after reset
    for (int s = 0; s < 6; s++) begin
      probe(s, 32'h10, 1, 0, 0);
      note(acc_cause == 3'd1 && acc_fault, "R1", "cause after reset", acc_cause, 1);
    end

    // Sweep: covers R3, R4, R5, R6, R7, R8, R9, R10 and the R11 priority
    for (int c = 0; c < NCFG; c++) begin
      logic [31:0] offs [10];
      logic [31:0] lim32;
      lim32 = 32'(eff_limit(c));
      offs[0] = 32'h0;        offs[1] = 32'h3;
      offs[2] = lim32 - 7;    offs[3] = lim32 - 3;
      offs[4] = lim32 - 1;    offs[5] = lim32;
      offs[6] = lim32 + 1;    offs[7] = 32'hFFFF;
      offs[8] = 32'h1_0002;   offs[9] = 32'hFFFF_FFFD;
      load(c % 6, 16'(c * 8 + 4), c);
      for (int o = 0; o < 10; o++)
        for (int k = 0; k < 4; k++)
          for (int sz = 0; sz < 4; sz++)
            for (int p = 0; p < 4; p++) begin
              int ec;
              logic [31:0] el;
              probe(c % 6, offs[o], k, sz, p);
              model(c, k, sz, p, offs[o], ec, el);
              // R11: cause encoding, priority and fault flag
              note(acc_cause == 3'(ec) && acc_fault == (ec != 0) &&
                   (ec != 0 || acc_lin == el),
                   tag_of(ec), "cause/lin",
                   {acc_cause, acc_lin}, {3'(ec), el});
            end
    end

    // R2: same-cycle load is invisible, next cycle it is visible
    // segment 2 currently holds config 8 (exec-only, level 2): read -> type fault
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 3'd2; ld_sel = 16'h000C; ld_desc = mk_desc(0);
    acc_valid = 1'b1; acc_seg = 3'd2; acc_off = 32'h40; acc_kind = 2'd1; acc_size = 2'd2; acc_cpl = 2'd0;
    #2;
    note(acc_cause == 3'd3, "R2", "old entry cause", acc_cause, 3);
    note(acc_sel == 16'h0044, "R2", "old selector", acc_sel, 16'h0044);
    @(negedge clk);
    ld_valid = 1'b0;
    #2;
    note(acc_cause == 3'd0 && acc_lin == 32'h0010_0040, "R2", "new entry lin", acc_lin, 32'h0010_0040);
    note(acc_sel == 16'h000C, "R2", "new selector", acc_sel, 16'h000C);

    // R12: indices past the bank
    probe(6, 32'h0, 1, 0, 0);
    note(acc_cause == 3'd1 && acc_fault, "R12", "seg 6 cause", acc_cause, 1);
    note(acc_sel == 16'h0, "R2", "seg 6 selector", acc_sel, 0);
    probe(7, 32'h0, 0, 0, 0);
    note(acc_cause == 3'd1 && acc_fault, "R12", "seg 7 cause", acc_cause, 1);

    // R13: idle request against an absent entry (segment 0 holds config 6)
    @(negedge clk);
    acc_valid = 1'b0; acc_seg = 3'd0; acc_kind = 2'd2; acc_cpl = 2'd3;
    #2;
    note(!acc_fault && acc_cause == 3'd0, "R13", "idle outputs", {acc_fault, acc_cause}, 0);

    // R1: reset mid-run wipes a present entry (segment 2 holds config 0)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    probe(2, 32'h40, 1, 0, 0);
    note(acc_cause == 3'd1, "R1", "cause after second reset", acc_cause, 1);

    @(negedge clk);
    acc_valid = 1'b0;
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule